// File: doc/BRIEF.md
# SD Command Phase Engine

This block runs the command phase of an SD/MMC host controller. Software loads a 32-bit argument and a 6-bit command index, then writes a control word with its start bit set. The engine shifts a 48-bit command frame, protected by CRC7, out on a single-bit CMD line. It advances only on cycles where an internal card-clock enable is high. Depending on a 4-bit mode field, it then waits for a short (48-bit) or long (136-bit) response, or for none at all. It can also wait for DAT0 to leave the busy state, or simply emit a run of initialization clocks with no command on the line.

When an operation ends, a sticky transfer-end flag is set, and software clears it by writing one to it. The interrupt output follows that flag, gated by an enable bit. A missing response and a CRC7 mismatch on a short response are each reported by their own status bit. A received response can be read from four 32-bit buffer words. The delay field held in the control word is stored and read back untouched; it is meant for pad delay logic elsewhere.

Top module: `sd_cmd_engine`

## Requirements
- R1: After reset, the control and status words read as zero, CMD is not driven (cmd_oe=0, cmd_o=1) and irq is 0.
- R2: A launch in any mode other than 8 drives, one bit per card-clock enable and MSB first, the frame {0, 1, opcode[5:0], arg[31:0], crc7, 1}. Here crc7 is the remainder of the first 40 frame bits times x^7 divided by x^7+x^3+1. The first bit appears on the first enable after the launch write.
- R3: Control bit 7 is the start bit. It reads 1 from the launch write until the operation ends, then clears by itself. Mode 0 (and any mode value other than 1, 2, 3 and 8) ends on the enable that follows the 48th frame bit, which releases CMD. The transfer-end flag (status bit 5) is set when an operation ends.
- R4: irq is high exactly while status bit 5 and status bit 6 (the interrupt enable) are both 1. Writing 1 to status bit 5 clears it.
- R5: Mode 1 (48-bit response): the response start bit may come on any of the 64 enables after CMD is released. After its 48th bit, buffer word 0 (address 4) holds frame bits 31:0 and word 1 (address 5) holds {16'b0, frame bits 47:32}, and the operation ends.
- R6: For a 48-bit response, status bit 0 is set when frame bits 7:1 differ from the CRC7 of frame bits 47:8, and stays 0 otherwise. Bits 0 and 4 are cleared at every launch.
- R7: Mode 2 (136-bit response): word 0 holds frame bits 127:96, word 1 bits 95:64, word 2 bits 63:32 and word 3 bits 31:0. Status bit 0 is never set by such a response.
- R8: If CMD stays high for all 64 enables after it is released, status bit 4 is set and the operation ends on the 64th of them. A start bit on the 64th enable is still accepted.
- R9: Mode 3 behaves as mode 1. After the response it stays busy until DAT0 is sampled high on an enable, and only then does it end.
- R10: Mode 8 sends no command and never drives CMD. It ends on enable number 8*N after the launch, where N is control bits 11:8.
- R11: Control bits 23:16 read back as last written, including after a launch and after the operation has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cclk_en | input | 1 | Card-clock enable; one pulse per card clock |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0 control, 1 status, 2 argument, 3 opcode, 4 to 7 response words 0 to 3 |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| cmd_o | output | 1 | CMD line output value |
| cmd_oe | output | 1 | CMD line output enable |
| cmd_i | input | 1 | CMD line input |
| dat0_i | input | 1 | DAT0 line input (low means card busy) |
| irq | output | 1 | Transfer-end interrupt |

## Verification
The properties assume that cclk_en comes as pulses separated by idle cycles, and that cmd_i idles high except while a card response is being sent. They also assume that the control word is not rewritten while an operation runs. The stimulus keeps to these assumptions: every card clock goes through one bench task that pulses the enable for a single cycle, and register writes are made only while the enable is low. The response line is returned high between operations, and each new launch is made only after the previous one has been seen to end.

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine #(
  parameter int RESP_WIN   = 64,
  parameter int INIT_BURST = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cclk_en,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        cmd_o,
  output logic        cmd_oe,
  input  logic        cmd_i,
  input  logic        dat0_i,
  output logic        irq
);
  localparam int CW = $clog2(RESP_WIN + 136 + 16 * INIT_BURST);

  typedef enum logic [2:0] {S_IDLE, S_TX, S_WAIT, S_RX, S_BUSY, S_INIT} st_t;

  function automatic logic [6:0] crc7(input logic [39:0] d);
    logic [6:0] c;
    logic fb;
    c = '0;
    for (int i = 39; i >= 0; i--) begin
      fb = d[i] ^ c[6];
      c  = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end
    return c;
  endfunction

  st_t           state;
  logic [31:0]   ctrl_q, arg_q, resp0, resp1, resp2, resp3;
  logic [5:0]    opc_q;
  logic          busy, te_flag, te_en, noresp, crc_err;
  logic [47:0]   txsh;
  logic [135:0]  rx, rx_nxt;
  logic [CW-1:0] cnt;
  logic [3:0]    mode;
  logic          has_resp, is_long;
  logic [7:0]    rlen;

  assign mode     = ctrl_q[3:0];
  assign has_resp = (mode == 4'd1) || (mode == 4'd2) || (mode == 4'd3);
  assign is_long  = (mode == 4'd2);
  assign rlen     = is_long ? 8'd136 : 8'd48;
  assign rx_nxt   = {rx[134:0], cmd_i};
  assign irq      = te_flag & te_en;

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {ctrl_q[31:8], busy, ctrl_q[6:0]};
      3'd1:    reg_rdata = {25'd0, te_en, te_flag, noresp, 3'd0, crc_err};
      3'd2:    reg_rdata = arg_q;
      3'd3:    reg_rdata = {26'd0, opc_q};
      3'd4:    reg_rdata = resp0;
      3'd5:    reg_rdata = resp1;
      3'd6:    reg_rdata = resp2;
      default: reg_rdata = resp3;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; ctrl_q <= '0; arg_q <= '0; opc_q <= '0;
      resp0 <= '0; resp1 <= '0; resp2 <= '0; resp3 <= '0;
      busy <= 1'b0; te_flag <= 1'b0; te_en <= 1'b0; noresp <= 1'b0; crc_err <= 1'b0;
      txsh <= '0; rx <= '0; cnt <= '0; cmd_o <= 1'b1; cmd_oe <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          3'd0: if (!busy) begin
            ctrl_q <= reg_wdata;
            if (reg_wdata[7]) begin
              busy <= 1'b1; noresp <= 1'b0; crc_err <= 1'b0;
              if (reg_wdata[3:0] == 4'd8) begin
                state <= S_INIT;
                cnt   <= CW'(reg_wdata[11:8]) * CW'(INIT_BURST);
              end else begin
                state <= S_TX;
                cnt   <= '0;
                txsh  <= {2'b01, opc_q, arg_q, crc7({2'b01, opc_q, arg_q}), 1'b1};
              end
            end
          end
          3'd1: begin
            te_en <= reg_wdata[6];
            if (reg_wdata[5]) te_flag <= 1'b0;
            if (reg_wdata[4]) noresp  <= 1'b0;
            if (reg_wdata[0]) crc_err <= 1'b0;
          end
          3'd2: arg_q <= reg_wdata;
          3'd3: opc_q <= reg_wdata[5:0];
          default: ;
        endcase
      end
      if (cclk_en) begin
        case (state)
          S_TX: begin
            if (cnt < CW'(48)) begin
              cmd_oe <= 1'b1;
              cmd_o  <= txsh[47];
              txsh   <= {txsh[46:0], 1'b0};
              cnt    <= cnt + 1'b1;
            end else begin
              cmd_oe <= 1'b0;
              cmd_o  <= 1'b1;
              cnt    <= '0;
              if (has_resp) state <= S_WAIT;
              else begin state <= S_IDLE; busy <= 1'b0; te_flag <= 1'b1; end
            end
          end
          S_WAIT: begin
            if (!cmd_i) begin
              state <= S_RX;
              rx    <= '0;
              cnt   <= CW'(1);
            end else if (cnt == CW'(RESP_WIN - 1)) begin
              noresp <= 1'b1;
              state  <= S_IDLE; busy <= 1'b0; te_flag <= 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          S_RX: begin
            rx  <= rx_nxt;
            cnt <= cnt + 1'b1;
            if (cnt == CW'(rlen - 8'd1)) begin
              if (is_long) begin
                resp0 <= rx_nxt[127:96]; resp1 <= rx_nxt[95:64];
                resp2 <= rx_nxt[63:32];  resp3 <= rx_nxt[31:0];
              end else begin
                resp0   <= rx_nxt[31:0];
                resp1   <= {16'd0, rx_nxt[47:32]};
                crc_err <= crc7(rx_nxt[47:8]) != rx_nxt[7:1];
              end
              if (mode == 4'd3) state <= S_BUSY;
              else begin state <= S_IDLE; busy <= 1'b0; te_flag <= 1'b1; end
            end
          end
          S_BUSY: if (dat0_i) begin state <= S_IDLE; busy <= 1'b0; te_flag <= 1'b1; end
          S_INIT: begin
            if (cnt <= CW'(1)) begin state <= S_IDLE; busy <= 1'b0; te_flag <= 1'b1; end
            else cnt <= cnt - 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  a_r2_start_bit_low: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_oe) |-> !cmd_o);
  a_r3_end_sets_flag: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> te_flag);
  a_r8_noresp_from_wait: assert property (@(posedge clk) disable iff (rst)
    $rose(noresp) |-> $past(state) == S_WAIT);
  a_r9_hold_while_dat0_low: assert property (@(posedge clk) disable iff (rst)
    (state == S_BUSY && !dat0_i) |=> busy);
  a_r10_init_never_drives: assert property (@(posedge clk) disable iff (rst)
    (state == S_INIT) |-> !cmd_oe);
endmodule

// File: tb/sim_sd_cmd_engine.sv
module sim_sd_cmd_engine;
  logic        clk = 0, rst = 1, cclk_en = 0, reg_wr = 0, cmd_i = 1, dat0_i = 1;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        cmd_o, cmd_oe, irq;
  int checks = 0, fails = 0;
  bit finished = 0;

  sd_cmd_engine u0 (.clk(clk), .rst(rst), .cclk_en(cclk_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cmd_o(cmd_o), .cmd_oe(cmd_oe), .cmd_i(cmd_i), .dat0_i(dat0_i), .irq(irq));

  always #4 clk = ~clk;

  function automatic logic [6:0] ref_crc(input logic [39:0] d);
    logic [46:0] r;
    r = {d, 7'd0};
    for (int i = 46; i >= 7; i--) if (r[i]) r[i -: 8] = r[i -: 8] ^ 8'h89;
    return r[6:0];
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic tick();
    @(negedge clk); cclk_en = 1;
    @(negedge clk); cclk_en = 0;
  endtask

  task automatic launch(input logic [5:0] opc, input logic [31:0] arg, input logic [31:0] ctl);
    wr(3'd2, arg); wr(3'd3, {26'd0, opc}); wr(3'd0, ctl | 32'h80);
  endtask

  task automatic send_frame(input logic [5:0] opc, input logic [31:0] arg, input string tag);
    logic [47:0] got, exp;
    int oe_cnt;
    oe_cnt = 0;
    exp = {2'b01, opc, arg, ref_crc({2'b01, opc, arg}), 1'b1};
    for (int i = 0; i < 48; i++) begin
      tick(); got = {got[46:0], cmd_o}; oe_cnt += cmd_oe;
    end
    chk({tag, " frame"}, got, exp);
    chk({tag, " oe count"}, oe_cnt, 48);
    tick();
    chk({tag, " released"}, {cmd_oe, cmd_o}, 2'b01);
  endtask

  task automatic respond(input logic [135:0] fr, input int len, input int dly);
    for (int i = 0; i < dly; i++) begin cmd_i = 1; tick(); end
    for (int i = len - 1; i >= 0; i--) begin cmd_i = fr[i]; tick(); end
    cmd_i = 1;
  endtask

  logic [31:0] v;

  initial begin
    #(8 * 190000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    rd(3'd0, v); chk("R1 ctrl", v, 0);
    rd(3'd1, v); chk("R1 status", v, 0);
    chk("R1 cmd pins", {cmd_oe, cmd_o, irq}, 3'b010);

    wr(3'd1, 32'h40);
    for (int op = 0; op < 64; op++) begin
      logic [31:0] a;
      a = (op * 32'h9E3779B1) ^ {op[7:0], 24'h5A3C1};
      launch(op[5:0], a, 32'h00A5_0000);
      rd(3'd0, v); chk("R3 start reads 1", v[7], 1);
      send_frame(op[5:0], a, "R2");
      rd(3'd0, v); chk("R3 start self-clears", v[7], 0);
      chk("R11 delay kept", v[23:16], 8'hA5);
      rd(3'd1, v); chk("R3 te flag", v[5], 1);
      chk("R4 irq on", irq, 1);
      wr(3'd1, 32'h60);
      rd(3'd1, v); chk("R4 w1c", v[5], 0);
      chk("R4 irq off", irq, 0);
    end

    wr(3'd1, 32'h00);
    launch(6'd7, 32'h1, 32'h0);
    send_frame(6'd7, 32'h1, "R3 mode0");
    rd(3'd1, v); chk("R4 flag without enable", v[6:5], 2'b01);
    chk("R4 irq gated", irq, 0);
    wr(3'd1, 32'h40);
    chk("R4 irq after enable", irq, 1);
    wr(3'd1, 32'h60);

    for (int k = 0; k < 8; k++) begin
      logic [31:0] st;
      logic [47:0] rf;
      int d;
      st = 32'hC0DE_0000 + k * 32'h1111_0137;
      rf = {2'b00, 6'(k + 17), st, 7'd0, 1'b1};
      rf[7:1] = ref_crc(rf[47:8]);
      d = (k == 7) ? 63 : k;
      launch(6'(k + 17), st, 32'h0012_0001);
      send_frame(6'(k + 17), st, "R5 tx");
      respond({88'd0, rf}, 48, d);
      rd(3'd0, v); chk("R5 done", v[7], 0);
      chk("R11 delay after resp", v[23:16], 8'h12);
      rd(3'd4, v); chk("R5 word0", v, rf[31:0]);
      rd(3'd5, v); chk("R5 word1", v, {16'd0, rf[47:32]});
      rd(3'd1, v); chk("R6 crc ok", v[0], 0);
      chk("R8 start on last slot accepted", v[4], 0);
      wr(3'd1, 32'h60);
    end

    begin
      logic [47:0] rf;
      rf = {2'b00, 6'd13, 32'h0000_0900, 7'd0, 1'b1};
      rf[7:1] = ref_crc(rf[47:8]) ^ 7'h04;
      launch(6'd13, 0, 32'h1);
      send_frame(6'd13, 0, "R6 tx");
      respond({88'd0, rf}, 48, 2);
      rd(3'd1, v); chk("R6 crc error", v[0], 1);
      wr(3'd1, 32'h60);
      launch(6'd13, 0, 32'h0);
      rd(3'd1, v); chk("R6 cleared at launch", v[0], 0);
      send_frame(6'd13, 0, "R6 tx2");
      wr(3'd1, 32'h60);
    end

    begin
      logic [135:0] lf;
      lf = {2'b00, 6'h3F, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3211};
      launch(6'd2, 0, 32'h2);
      send_frame(6'd2, 0, "R7 tx");
      respond(lf, 136, 5);
      rd(3'd0, v); chk("R7 done", v[7], 0);
      rd(3'd4, v); chk("R7 word0", v, lf[127:96]);
      rd(3'd5, v); chk("R7 word1", v, lf[95:64]);
      rd(3'd6, v); chk("R7 word2", v, lf[63:32]);
      rd(3'd7, v); chk("R7 word3", v, lf[31:0]);
      rd(3'd1, v); chk("R7 no crc flag", v[0], 0);
      wr(3'd1, 32'h60);
    end

    launch(6'd8, 32'h1AA, 32'h1);
    send_frame(6'd8, 32'h1AA, "R8 tx");
    cmd_i = 1;
    for (int i = 0; i < 63; i++) tick();
    rd(3'd0, v); chk("R8 busy at 63", v[7], 1);
    tick();
    rd(3'd0, v); chk("R8 ends at 64", v[7], 0);
    rd(3'd1, v); chk("R8 noresp flag", v[5:4], 2'b11);
    wr(3'd1, 32'h70);

    begin
      logic [47:0] rf;
      rf = {2'b00, 6'd12, 32'h0000_0B00, 7'd0, 1'b1};
      rf[7:1] = ref_crc(rf[47:8]);
      dat0_i = 0;
      launch(6'd12, 0, 32'h3);
      send_frame(6'd12, 0, "R9 tx");
      respond({88'd0, rf}, 48, 1);
      rd(3'd0, v); chk("R9 busy after resp", v[7], 1);
      for (int i = 0; i < 5; i++) tick();
      rd(3'd0, v); chk("R9 still busy dat0 low", v[7], 1);
      rd(3'd1, v); chk("R9 no flag yet", v[5], 0);
      dat0_i = 1; tick();
      rd(3'd0, v); chk("R9 ends on dat0 high", v[7], 0);
      rd(3'd5, v); chk("R9 word1", v, {16'd0, rf[47:32]});
      wr(3'd1, 32'h60);
    end

    foreach (v[i]) if (i < 2) begin
      int n, oe;
      n = (i == 0) ? 5 : 1;
      oe = 0;
      wr(3'd0, 32'h0033_0088 | (n << 8));
      for (int t = 0; t < 8 * n - 1; t++) begin tick(); oe += cmd_oe; end
      rd(3'd0, v); chk("R10 busy before last", v[7], 1);
      tick(); oe += cmd_oe;
      rd(3'd0, v); chk("R10 ends on 8N", v[7], 0);
      chk("R11 delay after init", v[23:16], 8'h33);
      chk("R10 cmd never driven", oe, 0);
      rd(3'd1, v); chk("R10 flag", v[5], 1);
      wr(3'd1, 32'h60);
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule